// File: doc/BRIEF.md
# Chip-Select Sequencer with Setup and Release Delays

This block controls an 8-line active-low chip-select bus around each word that a separate shift engine serialises. Software, or a DMA engine, writes one 32-bit command word. The command carries the transmit data, the chip-select pattern to drive and a hold flag. Writing the command starts a transfer.

The sequencer first drives the pattern. It then waits a programmable number of clock cycles before it pulses a start request to the shifter. When the shifter reports that its last clock edge is done, the sequencer does one of two things:

- If the hold flag is set, it keeps the pattern on the bus so that the next word continues the same frame.
- If the hold flag is clear, it waits a second programmable delay and then returns the lines to an idle default pattern held in its own register.

A held word followed by a word with the same pattern skips the setup wait. The shifting itself and interrupt generation sit outside this block.

Top module: `cs_seq_ctrl`

## Requirements
- R1: After reset `cs_n_o` equals 8'hFF, `shf_start_o` is low and `wr_ready_o` is high.
- R2: An accepted command (`wr_valid_i` and `wr_ready_o` high at a clock edge) is decoded as follows. Bits 15:0 carry the data, which appears on `shf_data_o`. Bits 23:16 carry the pattern, which is driven on `cs_n_o` from the next cycle. Bit 28 is the hold flag. A 0 bit in the pattern selects that line, and a 1 bit leaves it high.
- R3: The setup delay is `dly_word_i[31:24]`. The one-cycle `shf_start_o` pulse comes that many cycles after the first cycle in which the new pattern is driven. A setup delay of 0 puts the pulse in that first cycle.
- R4: The release delay is `dly_word_i[23:16]`. When `shf_done_i` is seen with hold clear, the pattern stays on `cs_n_o` for that many more cycles and then the lines go to the idle default. A release delay of 0 gives the default in the cycle after `shf_done_i`.
- R5: When `shf_done_i` is seen with hold set, the pattern stays on `cs_n_o` with no release wait, and `wr_ready_o` goes high in the next cycle.
- R6: A command accepted while a held pattern is on the bus, with the same pattern, pulses `shf_start_o` in the first cycle after acceptance, whatever the setup delay is.
- R7: A command accepted while a held pattern is on the bus, with a different pattern, drives the new pattern at once and waits the full setup delay.
- R8: The idle default register resets to 8'hFF. A `def_wr_i` write loads `def_pat_i`, and the new value appears on `cs_n_o` in the next idle cycle.
- R9: `wr_ready_o` is low from acceptance until the block is idle or holding. A command offered while it is low is ignored: `cs_n_o`, `shf_data_o` and the start pulse are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Command write strobe |
| wr_word_i | input | 32 | Command: data, pattern, hold flag |
| wr_ready_o | output | 1 | Command can be accepted |
| dly_wr_i | input | 1 | Delay register write strobe |
| dly_word_i | input | 32 | Setup delay [31:24], release delay [23:16] |
| def_wr_i | input | 1 | Idle default register write strobe |
| def_pat_i | input | 8 | Idle default chip-select levels |
| cs_n_o | output | 8 | Active-low chip-select lines |
| shf_start_o | output | 1 | One-cycle start request to the shifter |
| shf_data_o | output | 16 | Data word for the shifter |
| shf_done_i | input | 1 | Shifter has completed its last clock edge |

## Verification
The assertions check four properties on every cycle:

- the start request is a single-cycle pulse;
- a held pattern does not move after the shifter finishes;
- a zero release delay returns the lines to the default in the very next cycle;
- data and pattern do not move when a command is offered while the block is busy.

The exact cycle counts of the setup and release waits, and the skip for a repeated held pattern, can only be shown by the bench's scenarios. The same applies to the switch to a new pattern under hold and to a reprogrammed idle default. The bench measures these counts at the ports for several delay values, including zero.

// File: rtl/cs_seq_pkg.sv
package cs_seq_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned DATA_LSB = 0;
  localparam int unsigned PAT_LSB  = 16;
  localparam int unsigned HOLD_BIT = 28;
  localparam int unsigned SETUP_LSB = 24;
  localparam int unsigned REL_LSB  = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_START,
    ST_BUSY,
    ST_TAIL,
    ST_HOLD
  } seq_state_e;
endpackage

// File: rtl/cs_seq_dly_cnt.sv
module cs_seq_dly_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         last_o,
  output logic         busy_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == W'(1));
  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/cs_seq_cfg.sv
module cs_seq_cfg #(
  parameter int unsigned CS_W  = 8,
  parameter int unsigned DLY_W = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         dly_wr_i,
  input  logic [cs_seq_pkg::WORD_W-1:0] dly_word_i,
  input  logic                         def_wr_i,
  input  logic [CS_W-1:0]              def_pat_i,
  output logic [DLY_W-1:0]             setup_dly_o,
  output logic [DLY_W-1:0]             rel_dly_o,
  output logic [CS_W-1:0]              def_pat_o
);
  import cs_seq_pkg::*;

  logic [DLY_W-1:0] setup_q, rel_q;
  logic [CS_W-1:0]  def_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      setup_q <= '0;
      rel_q   <= '0;
      def_q   <= '1;
    end else begin
      if (dly_wr_i) begin
        setup_q <= dly_word_i[SETUP_LSB +: DLY_W];
        rel_q   <= dly_word_i[REL_LSB +: DLY_W];
      end
      if (def_wr_i) def_q <= def_pat_i;
    end
  end

  logic unused_dly_bits;
  assign unused_dly_bits = ^dly_word_i[REL_LSB-1:0];

  assign setup_dly_o = setup_q;
  assign rel_dly_o   = rel_q;
  assign def_pat_o   = def_q;
endmodule

// File: rtl/cs_seq_ctrl.sv
module cs_seq_ctrl #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CS_W   = 8,
  parameter int unsigned DLY_W  = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_valid_i,
  input  logic [cs_seq_pkg::WORD_W-1:0] wr_word_i,
  output logic                          wr_ready_o,
  input  logic                          dly_wr_i,
  input  logic [cs_seq_pkg::WORD_W-1:0] dly_word_i,
  input  logic                          def_wr_i,
  input  logic [CS_W-1:0]               def_pat_i,
  output logic [CS_W-1:0]               cs_n_o,
  output logic                          shf_start_o,
  output logic [DATA_W-1:0]             shf_data_o,
  input  logic                          shf_done_i
);
  import cs_seq_pkg::*;

  seq_state_e       state_q, state_d;
  logic [DATA_W-1:0] data_q;
  logic [CS_W-1:0]  pat_q;
  logic             hold_q;
  logic [DLY_W-1:0] setup_dly, rel_dly;
  logic [CS_W-1:0]  def_pat;
  logic             cnt_load, cnt_last, cnt_busy;
  logic [DLY_W-1:0] cnt_val;

  logic [DATA_W-1:0] in_data;
  logic [CS_W-1:0]   in_pat;
  logic              in_hold;
  logic              wr_fire, same_held, rel_load;

  assign in_data = wr_word_i[DATA_LSB +: DATA_W];
  assign in_pat  = wr_word_i[PAT_LSB +: CS_W];
  assign in_hold = wr_word_i[HOLD_BIT];

  logic unused_cmd_bits;
  assign unused_cmd_bits = ^{wr_word_i[WORD_W-1:HOLD_BIT+1], wr_word_i[HOLD_BIT-1:PAT_LSB+CS_W]};

  cs_seq_cfg #(.CS_W(CS_W), .DLY_W(DLY_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dly_wr_i   (dly_wr_i),
    .dly_word_i (dly_word_i),
    .def_wr_i   (def_wr_i),
    .def_pat_i  (def_pat_i),
    .setup_dly_o(setup_dly),
    .rel_dly_o  (rel_dly),
    .def_pat_o  (def_pat)
  );

  // One counter serves both waits; the phases never overlap.
  cs_seq_dly_cnt #(.W(DLY_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (cnt_load),
    .load_val_i(cnt_val),
    .last_o    (cnt_last),
    .busy_o    (cnt_busy)
  );

  assign wr_ready_o = (state_q == ST_IDLE) || (state_q == ST_HOLD);
  assign wr_fire    = wr_valid_i && wr_ready_o;
  assign same_held  = (state_q == ST_HOLD) && (in_pat == pat_q);
  assign rel_load   = (state_q == ST_BUSY) && shf_done_i && !hold_q && (rel_dly != '0);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_HOLD:
        if (wr_fire) begin
          if (same_held || setup_dly == '0) state_d = ST_START;
          else                              state_d = ST_SETUP;
        end
      ST_SETUP: if (cnt_last) state_d = ST_START;
      ST_START: state_d = ST_BUSY;
      ST_BUSY:
        if (shf_done_i) begin
          if (hold_q)              state_d = ST_HOLD;
          else if (rel_dly == '0)  state_d = ST_IDLE;
          else                     state_d = ST_TAIL;
        end
      ST_TAIL: if (cnt_last) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign cnt_load = (wr_fire && state_d == ST_SETUP) || rel_load;
  assign cnt_val  = rel_load ? rel_dly : setup_dly;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
      pat_q   <= '1;
      hold_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (wr_fire) begin
        data_q <= in_data;
        pat_q  <= in_pat;
        hold_q <= in_hold;
      end
    end
  end

  assign cs_n_o      = (state_q == ST_IDLE) ? def_pat : pat_q;
  assign shf_start_o = (state_q == ST_START);
  assign shf_data_o  = data_q;

  p_start_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shf_start_o |=> !shf_start_o);

  p_setup_cnt_live_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETUP) |-> cnt_busy);

  p_zero_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BUSY && shf_done_i && !hold_q && rel_dly == '0) |=> (cs_n_o == def_pat));

  p_hold_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BUSY && shf_done_i && hold_q) |=> ($stable(cs_n_o) && wr_ready_o));

  p_busy_ignore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ready_o) |=> ($stable(shf_data_o) && $stable(pat_q)));
endmodule

// File: tb/cs_seq_ctrl_tb_top.sv
module cs_seq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_word = '0;
  logic        wr_ready;
  logic        dly_wr = 1'b0;
  logic [31:0] dly_word = '0;
  logic        def_wr = 1'b0;
  logic [7:0]  def_pat = '0;
  logic [7:0]  cs_n;
  logic        shf_start;
  logic [15:0] shf_data;
  logic        shf_done = 1'b0;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cs_seq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_word_i(wr_word), .wr_ready_o(wr_ready),
    .dly_wr_i(dly_wr), .dly_word_i(dly_word),
    .def_wr_i(def_wr), .def_pat_i(def_pat),
    .cs_n_o(cs_n), .shf_start_o(shf_start), .shf_data_o(shf_data),
    .shf_done_i(shf_done)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic set_delays(input logic [7:0] su, input logic [7:0] rel);
    @(negedge clk);
    dly_word = {su, rel, 16'h0000};
    dly_wr = 1'b1;
    @(negedge clk);
    dly_wr = 1'b0;
  endtask

  // Ends at the first negedge after the accepting edge.
  task automatic send(input logic [15:0] d, input logic [7:0] p, input logic h);
    @(negedge clk);
    wr_word = {3'b000, h, 4'h0, p, d};
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_start(output int n);
    n = 0;
    while (!shf_start && n < 300) begin
      @(negedge clk);
      n++;
    end
  endtask

  // Called at the start negedge; done raised one cycle later.
  task automatic finish_word(input logic [7:0] p, output int n);
    @(negedge clk);
    shf_done = 1'b1;
    @(negedge clk);
    shf_done = 1'b0;
    n = 0;
    while (cs_n == p && n < 300) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset;
    chk("R1 cs idle", 32'(cs_n), 32'hFF);
    chk("R1 start low", 32'(shf_start), 0);
    chk("R1 ready", 32'(wr_ready), 1);
  endtask

  task automatic t_basic;
    int n;
    set_delays(8'd3, 8'd2);
    send(16'hA55A, 8'hFE, 1'b0);
    chk("R2 pattern driven", 32'(cs_n), 32'hFE);
    chk("R2 data", 32'(shf_data), 32'hA55A);
    chk("R9 ready low", 32'(wr_ready), 0);
    wait_start(n);
    chk("R3 setup cycles", n, 3);
    finish_word(8'hFE, n);
    chk("R4 release cycles", n, 2);
    chk("R4 back to default", 32'(cs_n), 32'hFF);
    chk("R9 ready back", 32'(wr_ready), 1);
  endtask

  task automatic t_zero;
    int n;
    set_delays(8'd0, 8'd0);
    send(16'h1234, 8'hF7, 1'b0);
    chk("R3 zero setup start", 32'(shf_start), 1);
    chk("R2 pattern zero", 32'(cs_n), 32'hF7);
    @(negedge clk);
    chk("R3 single pulse", 32'(shf_start), 0);
    shf_done = 1'b1;
    @(negedge clk);
    shf_done = 1'b0;
    chk("R4 zero release", 32'(cs_n), 32'hFF);
  endtask

  task automatic t_hold;
    int n;
    set_delays(8'd5, 8'd4);
    send(16'h0001, 8'hBF, 1'b1);
    wait_start(n);
    chk("R3 setup five", n, 5);
    @(negedge clk);
    shf_done = 1'b1;
    @(negedge clk);
    shf_done = 1'b0;
    chk("R5 pattern held", 32'(cs_n), 32'hBF);
    chk("R5 ready when held", 32'(wr_ready), 1);
    repeat (6) @(negedge clk);
    chk("R5 still held", 32'(cs_n), 32'hBF);
    send(16'h0002, 8'hBF, 1'b1);
    chk("R6 same pattern skip", 32'(shf_start), 1);
    chk("R6 data", 32'(shf_data), 32'h0002);
    @(negedge clk);
    shf_done = 1'b1;
    @(negedge clk);
    shf_done = 1'b0;
    send(16'h0003, 8'hDF, 1'b0);
    chk("R7 new pattern", 32'(cs_n), 32'hDF);
    wait_start(n);
    chk("R7 full setup", n, 5);
    finish_word(8'hDF, n);
    chk("R7 release after", n, 4);
  endtask

  task automatic t_default;
    int n;
    @(negedge clk);
    def_pat = 8'hF0;
    def_wr = 1'b1;
    @(negedge clk);
    def_wr = 1'b0;
    chk("R8 new default", 32'(cs_n), 32'hF0);
    set_delays(8'd1, 8'd1);
    send(16'h7777, 8'h7F, 1'b0);
    wait_start(n);
    finish_word(8'h7F, n);
    chk("R8 release to new default", 32'(cs_n), 32'hF0);
    @(negedge clk);
    def_pat = 8'hFF;
    def_wr = 1'b1;
    @(negedge clk);
    def_wr = 1'b0;
    chk("R8 restored", 32'(cs_n), 32'hFF);
  endtask

  task automatic t_busy;
    int n;
    int starts;
    set_delays(8'd2, 8'd0);
    send(16'hCAFE, 8'hEF, 1'b0);
    wait_start(n);
    @(negedge clk);
    wr_word = {3'b000, 1'b1, 4'h0, 8'h00, 16'hDEAD};
    wr_valid = 1'b1;
    chk("R9 busy not ready", 32'(wr_ready), 0);
    @(negedge clk);
    wr_valid = 1'b0;
    chk("R9 pattern unchanged", 32'(cs_n), 32'hEF);
    chk("R9 data unchanged", 32'(shf_data), 32'hCAFE);
    shf_done = 1'b1;
    @(negedge clk);
    shf_done = 1'b0;
    chk("R9 released", 32'(cs_n), 32'hFF);
    starts = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (shf_start) starts++;
    end
    chk("R9 dropped word no start", starts, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_zero();
    t_hold();
    t_default();
    t_busy();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog R1..: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule